// File: doc/BRIEF.md
# Saturating Decimal Millisecond Timer with Best-Time Register

This block measures a reaction interval in whole milliseconds and keeps the shortest interval seen so far. A three-digit packed-BCD counter advances by one decimal unit on every millisecond tick while the run input is high. It stops at 999 so that a slow response reads as the top of the scale instead of wrapping. A separate clear input returns the count to zero before a new measurement.

When run drops, the measurement is complete. The block then compares the count against a stored best time and keeps the smaller of the two. The best time starts at 999 after reset. A dedicated best-reset input sets it back to 999 without disturbing the running count. Both values leave the block as packed BCD, so a display stage can show each nibble directly as a decimal digit. Tick generation and display formatting belong to neighbouring blocks.

Top module: `reactionMsTimer`

## Requirements
- R1: The count does not change in a cycle where run is low or the tick is low, unless clear is high.
- R2: With run and tick both high, the count advances by one decimal unit at the clock edge. A low digit of 9 rolls to 0 and carries, so 0x009 becomes 0x010.
- R3: The carry ripples through higher digits in the same way, so 0x099 becomes 0x100 and 0x199 becomes 0x200.
- R4: At 0x999 the count holds, even while run and tick stay high.
- R5: Clear sets the count to 0x000 at the next edge and wins over an increment requested in the same cycle.
- R6: After reset the count reads 0x000 and the best time reads 0x999.
- R7: Best-reset sets the best time to 0x999 at the next edge.
- R8: In the first cycle where run is low after being high, the current count is compared with the best time. If the count is smaller, it becomes the best time at that edge. Otherwise the best time is unchanged.
- R9: When best-reset and a falling run edge coincide, the best time becomes 0x999.
- R10: Every 4-bit digit of the count and of the best time always lies in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bestClear | input | 1 | Sets the best time to 999 |
| runEn | input | 1 | Measurement running; a falling level ends a measurement |
| clearCount | input | 1 | Returns the count to zero |
| msTick | input | 1 | One-cycle pulse per millisecond |
| curTime | output | 12 | Current count, packed BCD |
| bestTime | output | 12 | Shortest completed count, packed BCD |

## Verification
Every result is due one clock edge after its stimulus. The count is registered directly from run, tick and clear. The best time is registered in the cycle where run is first seen low, and that cycle depends only on the previous cycle's registered run. The bench applies inputs one time unit after a rising edge and reads the outputs one time unit after the following rising edge. Each check therefore sees exactly the one register update that its stimulus caused. Expected values come from a decimal model in the bench that converts integers to BCD.

// File: rtl/msTimerPkg.sv
package msTimerPkg;
  localparam int DIGIT_W = 4;

  typedef struct packed {
    logic clrCount;
    logic incCount;
    logic updBest;
    logic rstBest;
  } ctlStrobes_t;
endpackage

// File: rtl/msTimerCtrl.sv
module msTimerCtrl
  import msTimerPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        msTick,
  input  logic        clearCount,
  input  logic        bestClear,
  output ctlStrobes_t strobes
);
  logic runQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runQ <= 1'b0;
    else       runQ <= runEn;
  end

  always_comb begin
    strobes.clrCount = clearCount;
    strobes.incCount = runEn & msTick;
    strobes.updBest  = runQ & ~runEn;
    strobes.rstBest  = bestClear;
  end

  // R8: an update strobe lasts one cycle per falling run edge
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updBest |=> !strobes.updBest);
endmodule

// File: rtl/msTimerDatapath.sv
module msTimerDatapath
  import msTimerPkg::*;
#(
  parameter int DIGITS = 3,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  output logic [W-1:0] countQ,
  output logic [W-1:0] bestQ
);
  localparam logic [W-1:0] MAX_BCD = {DIGITS{4'h9}};

  logic [DIGITS:0] carry;
  logic [W-1:0]    rippled;
  logic [W-1:0]    countNext;

  assign carry[0] = strobes.incCount;

  for (genvar i = 0; i < DIGITS; i++) begin : gDigit
    logic [DIGIT_W-1:0] digit;
    logic               isNine;
    assign digit  = countQ[i*DIGIT_W +: DIGIT_W];
    assign isNine = (digit == 4'd9);
    assign carry[i+1] = carry[i] & isNine;
    assign rippled[i*DIGIT_W +: DIGIT_W] =
      !carry[i] ? digit : (isNine ? 4'd0 : digit + 4'd1);

    // R10: each digit stays decimal
    a_r10_count_digit: assert property (@(posedge clk) disable iff (!rstN)
      countQ[i*DIGIT_W +: DIGIT_W] <= 4'd9);
    a_r10_best_digit: assert property (@(posedge clk) disable iff (!rstN)
      bestQ[i*DIGIT_W +: DIGIT_W] <= 4'd9);
  end

  // A carry out of the top digit means every digit is 9: hold (saturate)
  assign countNext = carry[DIGITS] ? countQ : rippled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 countQ <= '0;
    else if (strobes.clrCount) countQ <= '0;
    else                       countQ <= countNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    bestQ <= MAX_BCD;
    else if (strobes.rstBest)                     bestQ <= MAX_BCD;
    else if (strobes.updBest && (countQ < bestQ)) bestQ <= countQ;
  end

  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.incCount && !strobes.clrCount) |=> $stable(countQ));
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == MAX_BCD && !strobes.clrCount) |=> countQ == MAX_BCD);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrCount |=> countQ == '0);
  a_r7_best_reset: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rstBest |=> bestQ == MAX_BCD);
  a_r8_best_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rstBest |=> bestQ <= $past(bestQ));
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.rstBest && !strobes.updBest) |=> $stable(bestQ));
endmodule

// File: rtl/reactionMsTimer.sv
module reactionMsTimer
  import msTimerPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bestClear,
  input  logic        runEn,
  input  logic        clearCount,
  input  logic        msTick,
  output logic [11:0] curTime,
  output logic [11:0] bestTime
);
  localparam int DIGITS = 3;

  ctlStrobes_t strobes;

  msTimerCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .msTick     (msTick),
    .clearCount (clearCount),
    .bestClear  (bestClear),
    .strobes    (strobes)
  );

  msTimerDatapath #(.DIGITS(DIGITS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .countQ  (curTime),
    .bestQ   (bestTime)
  );
endmodule

// File: tb/reactionMsTimer_bench.sv
module reactionMsTimer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bestClear = 1'b0, runEn = 1'b0, clearCount = 1'b0, msTick = 1'b0;
  logic [11:0] curTime, bestTime;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reactionMsTimer u_reactionMsTimer (
    .clk(clk), .rstN(rstN), .bestClear(bestClear), .runEn(runEn),
    .clearCount(clearCount), .msTick(msTick),
    .curTime(curTime), .bestTime(bestTime)
  );

  function automatic logic [11:0] toBcd(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%03h expected=0x%03h", req, act, exp);
    end
  endtask

  // apply inputs for one cycle, return one unit after the edge
  task automatic cyc(input logic r, input logic t, input logic c, input logic b);
    runEn = r; msTick = t; clearCount = c; bestClear = b;
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 0);
  endtask

  task automatic testReset();
    check("R6 count", curTime, 12'h000);
    check("R6 best", bestTime, 12'h999);
  endtask

  task automatic testHold();
    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
    check("R1 run no tick", curTime, 12'h000);
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);
    check("R1 tick no run", curTime, 12'h000);
  endtask

  task automatic testCount();
    cyc(0, 0, 1, 0);
    ticks(9);  check("R2 nine", curTime, toBcd(9));
    ticks(1);  check("R2 ten", curTime, 12'h010);
    ticks(89); check("R3 99", curTime, 12'h099);
    ticks(1);  check("R3 100", curTime, 12'h100);
    ticks(99); check("R3 199", curTime, 12'h199);
    ticks(1);  check("R3 200", curTime, 12'h200);
    cyc(1, 0, 0, 0); cyc(0, 1, 0, 0);
    check("R1 hold mid", curTime, 12'h200);
    ticks(357); check("R2 557", curTime, toBcd(557));
  endtask

  task automatic testSaturate();
    ticks(442); check("R4 reach 999", curTime, 12'h999);
    ticks(20);  check("R4 hold 999", curTime, 12'h999);
  endtask

  task automatic testClear();
    cyc(1, 1, 1, 0);
    check("R5 clear over inc", curTime, 12'h000);
    ticks(5); cyc(0, 0, 1, 0);
    check("R5 clear", curTime, 12'h000);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0); // settle run edge from above
    cyc(0, 0, 0, 1);
  endtask

  task automatic measure(input int n, input logic [11:0] expBest, input string req);
    cyc(0, 0, 1, 0);
    ticks(n);
    cyc(0, 0, 0, 0);
    check(req, bestTime, expBest);
    check("R1 after stop", curTime, toBcd(n));
  endtask

  task automatic testBest();
    measure(25, 12'h025, "R8 first best");
    measure(40, 12'h025, "R8 slower kept");
    measure(7, 12'h007, "R8 faster taken");
    measure(130, 12'h007, "R8 bcd order");
    cyc(0, 0, 0, 1);
    check("R7 best reset", bestTime, 12'h999);
    measure(312, 12'h312, "R8 after reset");
    cyc(0, 0, 1, 0); ticks(3);
    cyc(0, 0, 0, 1);
    check("R9 reset wins", bestTime, 12'h999);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    testReset();
    testHold();
    testCount();
    testSaturate();
    testClear();
    testBest();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule